// File: doc/BRIEF.md
# Line-Typed Ping-Pong Socket Steering

This block sits behind a parallel capture port clocked by the pixel clock. Data arrives in lines framed by a line-valid input. A type input marks each line as either an image line or an info line. Every word of a line goes to the output with a write strobe and a destination socket index, one clock after it arrives. Image lines go to a pair of buffer sockets in strict alternation. Info lines always go to a third socket of their own. The buffers downstream expect every line to fill exactly one buffer, so the block emits a one-cycle commit pulse, tagged with the socket, when a line closes.

The sending side must deliver image lines in back-to-back pairs, with info lines allowed only between pairs. The block keeps the alternation correct across any interleaving of info lines. It raises sticky error flags in two cases: an info line splits an image pair, or a line does not carry exactly one buffer's worth of words. Words past the buffer size are dropped. The commit still happens.

Top module: `ppl_router`

## Requirements
- R1: After reset, image lines are steered to socket 0, then 1, then 0, and so on. The pair pointer advances once, when an image line completes.
- R2: Info lines are steered to socket 2, whatever the pair pointer is, and leave the pair pointer unchanged.
- R3: `sel_info` (1 = info, 0 = image) is sampled in the cycle `href` rises. Changes while `href` stays high do not alter the socket of that line.
- R4: Every cycle with `href` high, up to `LINE_WORDS` words per line, produces `wr_en` = 1 in the next cycle. In that cycle `wr_data` equals the input word and `wr_sock` equals the line's socket.
- R5: The first cycle `href` is sampled low after a line is followed, one clock later, by `commit` high for exactly one cycle. In that cycle `commit_sock` equals the line's socket. This happens for lines of any length.
- R6: If an info line starts while exactly one image line of a pair has completed, `err_order` goes high. It stays high until reset.
- R7: If a line closes with a word count other than `LINE_WORDS`, `err_len` goes high in the same cycle as that line's commit. It stays high until reset.
- R8: Words beyond `LINE_WORDS` in one line produce no `wr_en`.
- R9: A synchronous active-high `rst` clears `wr_en`, `commit`, `err_order` and `err_len`, and returns the pair pointer to socket 0.
- R10: `wr_en` and `commit` are never high in the same cycle, and `wr_sock` never reads 3 while `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| href | input | 1 | Line-valid; each high cycle carries one word |
| sel_info | input | 1 | Line type, sampled at line start: 1 info, 0 image |
| din | input | DATA_W | Input data word |
| wr_en | output | 1 | Word write strobe |
| wr_sock | output | 2 | Destination socket of the word: 0/1 image pair, 2 info |
| wr_data | output | DATA_W | Word being written |
| commit | output | 1 | One-cycle end-of-line buffer commit |
| commit_sock | output | 2 | Socket whose buffer is committed |
| err_order | output | 1 | Sticky image-pair ordering error |
| err_len | output | 1 | Sticky line-length error |

## Verification
The bench builds the block with `LINE_WORDS` = 8 and `DATA_W` = 32. Short lines keep a whole sequence of mixed image and info lines, plus short and overlong lines, within a few hundred cycles. This small line size lets the bench reach the pair pointer's wrap, the split-pair ordering fault, the overrun drop and the early-end commit quickly. A 2048-word line would take far longer per case and change none of the control paths.

// File: rtl/ppl_pkg.sv
package ppl_pkg;

    typedef enum logic [1:0] {
        SOCK_PING = 2'd0,
        SOCK_PONG = 2'd1,
        SOCK_INFO = 2'd2
    } sock_e;

    typedef enum logic {
        KIND_IMAGE = 1'b0,
        KIND_INFO  = 1'b1
    } kind_e;

    // per-cycle framing events derived from the line-valid input
    typedef struct packed {
        logic start;   // first word of a line
        logic word;    // a word is present this cycle
        logic fin;     // first idle cycle after a line
        logic fit;     // word still fits in the buffer
        logic len_bad; // closing line had the wrong count
    } frame_ev_t;

    function automatic sock_e pick_sock(input kind_e k, input logic pong);
        if (k == KIND_INFO) begin
            return SOCK_INFO;
        end
        return pong ? SOCK_PONG : SOCK_PING;
    endfunction

endpackage

// File: rtl/ppl_framer.sv
module ppl_framer
    import ppl_pkg::*;
#(
    parameter int LINE_WORDS = 2048
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      href,
    output frame_ev_t ev
);
    localparam int CW = $clog2(LINE_WORDS + 2);
    localparam logic [CW-1:0] FULL = CW'(LINE_WORDS);

    logic          href_q;
    logic [CW-1:0] cnt;

    always_comb begin
        ev.start   = href & ~href_q;
        ev.word    = href;
        ev.fin     = href_q & ~href;
        ev.fit     = ev.start | (cnt < FULL);
        ev.len_bad = ev.fin & (cnt != FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q <= 1'b0;
            cnt    <= '0;
        end else begin
            href_q <= href;
            if (ev.start) begin
                cnt <= CW'(1);
            end else if (href && cnt <= FULL) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (href && cnt > FULL) |=> (cnt == $past(cnt) || $past(ev.start)));

endmodule

// File: rtl/ppl_pair_track.sv
module ppl_pair_track
    import ppl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  kind_e kind_now,
    input  logic  fin,
    input  kind_e kind_line,
    output logic  pong,
    output logic  order_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pong      <= 1'b0;
            order_err <= 1'b0;
        end else begin
            if (fin && kind_line == KIND_IMAGE) begin
                pong <= ~pong;
            end
            if (start && kind_now == KIND_INFO && pong) begin
                order_err <= 1'b1;
            end
        end
    end

    // R1
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && kind_line == KIND_IMAGE) |=> (pong != $past(pong)));

    // R2
    info_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && kind_line == KIND_INFO) |=> $stable(pong));

endmodule

// File: rtl/ppl_router.sv
module ppl_router
    import ppl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              href,
    input  logic              sel_info,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [1:0]        wr_sock,
    output logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [1:0]        commit_sock,
    output logic              err_order,
    output logic              err_len
);
    frame_ev_t ev;
    kind_e     kind_q;
    kind_e     kind_now;
    logic      pong;
    logic      order_err;

    ppl_framer #(.LINE_WORDS(LINE_WORDS)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .href (href),
        .ev   (ev)
    );

    assign kind_now = ev.start ? kind_e'(sel_info) : kind_q;

    ppl_pair_track u_track (
        .clk       (clk),
        .rst       (rst),
        .start     (ev.start),
        .kind_now  (kind_now),
        .fin       (ev.fin),
        .kind_line (kind_q),
        .pong      (pong),
        .order_err (order_err)
    );

    assign err_order = order_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q      <= KIND_IMAGE;
            wr_en       <= 1'b0;
            wr_sock     <= 2'd0;
            wr_data     <= '0;
            commit      <= 1'b0;
            commit_sock <= 2'd0;
            err_len     <= 1'b0;
        end else begin
            if (ev.start) begin
                kind_q <= kind_e'(sel_info);
            end
            wr_en       <= ev.word & ev.fit;
            wr_sock     <= pick_sock(kind_now, pong);
            wr_data     <= din;
            commit      <= ev.fin;
            commit_sock <= pick_sock(kind_q, pong);
            if (ev.len_bad) begin
                err_len <= 1'b1;
            end
        end
    end

    // R5
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R10
    wr_commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && commit));

    // R10
    sock_legal_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_sock != 2'd3));

    // R6
    order_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_order |=> err_order);

    // R7
    len_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_len |=> err_len);

    // R7
    len_with_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_len) |-> commit);

endmodule

// File: tb/ppl_router_tb.sv
`timescale 1ns/1ps
module ppl_router_tb;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          href = 1'b0;
    logic          sel_info = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_en;
    logic [1:0]    wr_sock;
    logic [DW-1:0] wr_data;
    logic          commit;
    logic [1:0]    commit_sock;
    logic          err_order;
    logic          err_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppl_router #(.DATA_W(DW), .LINE_WORDS(LW)) u_dut (
        .clk(clk), .rst(rst), .href(href), .sel_info(sel_info), .din(din),
        .wr_en(wr_en), .wr_sock(wr_sock), .wr_data(wr_data),
        .commit(commit), .commit_sock(commit_sock),
        .err_order(err_order), .err_len(err_len)
    );

    // {info, len[4:0], flip, sock[1:0], exp_order, exp_len}
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 1'b0},
        {1'b0, 5'd8,  1'b1, 2'd1, 1'b0, 1'b0},
        {1'b1, 5'd8,  1'b1, 2'd2, 1'b0, 1'b0},
        {1'b1, 5'd8,  1'b0, 2'd2, 1'b0, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd1, 1'b0, 1'b0},
        {1'b1, 5'd8,  1'b0, 2'd2, 1'b0, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 1'b0},
        {1'b1, 5'd8,  1'b0, 2'd2, 1'b1, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd1, 1'b1, 1'b0},
        {1'b0, 5'd5,  1'b0, 2'd0, 1'b1, 1'b1},
        {1'b0, 5'd12, 1'b1, 2'd1, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_line(input int id, input logic info, input int len,
                             input logic flip, input logic [1:0] exp_sock,
                             input logic exp_ord, input logic exp_len);
        int writes = 0;
        int commits = 0;
        int both = 0;
        bit sock_ok = 1'b1;
        bit data_ok = 1'b1;
        logic [1:0] bad_sock = exp_sock;
        logic [1:0] csock = 2'd3;
        int exp_w = (len < LW) ? len : LW;
        string sreq = info ? "R2" : "R1";
        for (int i = 0; i < len + 2; i++) begin
            @(negedge clk);
            if (wr_en) begin
                if (wr_sock !== exp_sock) begin
                    sock_ok = 1'b0;
                    bad_sock = wr_sock;
                end
                if (wr_data !== {16'(id), 16'(writes)}) data_ok = 1'b0;
                writes++;
            end
            if (commit) begin
                commits++;
                csock = commit_sock;
            end
            if (wr_en && commit) both++;
            if (i < len) begin
                href = 1'b1;
                sel_info = (i == 0 || !flip) ? info : ~info;
                din = {16'(id), 16'(i)};
            end else begin
                href = 1'b0;
                sel_info = flip ? ~info : info;
                din = '0;
            end
        end
        chk(sock_ok, flip ? "R3" : sreq, "wr_sock", bad_sock, exp_sock);
        chk(writes == exp_w, (len > LW) ? "R8" : "R4", "write count", writes, exp_w);
        chk(data_ok, "R4", "wr_data sequence", data_ok, 1);
        chk(commits == 1 && csock == exp_sock, "R5", "commit count/sock",
            {commits[7:0], 6'd0, csock}, {8'd1, 6'd0, exp_sock});
        chk(both == 0, "R10", "wr_en with commit", both, 0);
        chk(err_order === exp_ord, "R6", "err_order", err_order, exp_ord);
        chk(err_len === exp_len, "R7", "err_len", err_len, exp_len);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        href = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        finish_run();
    end

    initial begin
        do_reset();
        // R9 reset state
        chk(wr_en === 1'b0 && commit === 1'b0, "R9", "strobes after reset",
            {wr_en, commit}, 0);
        chk(err_order === 1'b0 && err_len === 1'b0, "R9", "flags after reset",
            {err_order, err_len}, 0);

        for (int v = 0; v < NV; v++) begin
            send_line(v, VEC[v][10], int'(VEC[v][9:5]), VEC[v][4],
                      VEC[v][3:2], VEC[v][1], VEC[v][0]);
        end

        // leave the pointer at socket 1, then reset
        send_line(20, 1'b0, LW, 1'b0, 2'd0, 1'b1, 1'b1);
        do_reset();
        chk(err_order === 1'b0 && err_len === 1'b0, "R9", "flags cleared",
            {err_order, err_len}, 0);
        // R9: pointer back to socket 0
        send_line(21, 1'b0, LW, 1'b0, 2'd0, 1'b0, 1'b0);
        // R8 overrun alone, R7 set without order error
        send_line(22, 1'b0, LW + 3, 1'b0, 2'd1, 1'b0, 1'b1);
        // R7 sticky across a clean info line between pairs
        send_line(23, 1'b1, LW, 1'b0, 2'd2, 1'b0, 1'b1);
        // R1 single-word short line still alternates
        send_line(24, 1'b0, 1, 1'b0, 2'd0, 1'b0, 1'b1);

        finish_run();
    end
endmodule